// File: doc/BRIEF.md
# Quad-Channel Double-Latched DAC Code Register

This block is the digital front end of a four-channel converter with an 8-bit parallel data bus. A host presents a channel address and a data byte, then pulls an active-low write strobe. While the strobe is low, the addressed channel's staging register tracks the bus. On the rising edge of the strobe, that register holds the value on the bus in that cycle. A separate active-low load strobe moves all four staging values into the output code registers together, so the analog outputs can be updated at the same moment.

Both strobes act as levels. A low load strobe makes the output registers follow the staging registers. When the write strobe and the load strobe are low together, a byte on the bus reaches the addressed output one clock later.

Both storage levels are registers with clock enables in a single clock domain, not true latches. A synchronous active-low reset sets every register to zero scale.

Top module: `quad_dac_latch`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, every staging register and every output code becomes 00h after that edge, whatever the strobes, address and data are doing.
- R2: At an edge where `wr_n` is low, the staging register of channel `addr` takes `data` (0 → lane 0, bits [7:0]; 1 → lane 1, bits [15:8]; 2 → lane 2, bits [23:16]; 3 → lane 3, bits [31:24]), and no other staging register changes.
- R3: At the first edge where `wr_n` is high after an edge where it was low, the addressed staging register takes the `data` and `addr` present at that edge. This is the write-release capture.
- R4: At edges where `wr_n` is high and was also high at the previous edge, no staging register changes.
- R5: At edges where `load_n` is high and was also high at the previous edge, the output codes do not change.
- R6: At an edge where `load_n` is low, every output lane takes its staging register's value as updated at that same edge.
- R7: At the first edge where `load_n` is high after a low, every output lane takes its staging register's value as updated at that edge. This includes a write in progress in the same cycle.
- R8: With `wr_n` and `load_n` both low, the `data` at an edge appears on lane `addr` of `dac_code` right after that edge.
- R9: With both strobes high and neither just released, neither the staging registers nor the outputs change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all state updates on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset to zero scale |
| wr_n | input | 1 | Active-low write strobe for the addressed staging register |
| load_n | input | 1 | Active-low level load of all output code registers |
| addr | input | 2 | Channel select for writes |
| data | input | 8 | Parallel data bus |
| dac_code | output | 32 | Four output codes, lane n at bits [8n+7:8n] |

## Verification
The bench builds the block with its default parameters: four channels of eight bits. With these values the two-bit address covers every channel, so a write to each lane and every address code appear in the tests. Directed sequences cover the write-release capture, a load release that falls in the same cycle as an active write, the transparent path on all four lanes, and a reset applied while both strobes are low. A long stretch of random strobe, address and data patterns is compared every clock against a behavioural model. This puts the hold, follow and release cases next to one another in every combination.

// File: rtl/qdl_pkg.sv
package qdl_pkg;

  // What a strobe asks of the registers it governs in a given cycle.
  typedef enum logic [1:0] {
    ACT_HOLD   = 2'd0,
    ACT_FOLLOW = 2'd1,
    ACT_SEAL   = 2'd2
  } lat_act_e;

  // Classify a low-active strobe from its level now and at the prior edge.
  function automatic lat_act_e strobe_action(input logic lvl_n, input logic prev_n);
    if (!lvl_n) begin
      return ACT_FOLLOW;
    end
    if (!prev_n) begin
      return ACT_SEAL;
    end
    return ACT_HOLD;
  endfunction

  // Any action other than hold updates the governed storage.
  function automatic logic act_updates(input lat_act_e act);
    return act != ACT_HOLD;
  endfunction

endpackage

// File: rtl/qdl_strobe_track.sv
module qdl_strobe_track
  import qdl_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     strobe_n,
  output lat_act_e act,
  output logic     rise
);

  logic prev_n;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_n <= 1'b1;
    end else begin
      prev_n <= strobe_n;
    end
  end

  assign act  = strobe_action(strobe_n, prev_n);
  assign rise = (act == ACT_SEAL);

endmodule

// File: rtl/qdl_input_bank.sv
module qdl_input_bank
  import qdl_pkg::*;
#(
  parameter  int NUM_CH = 4,
  parameter  int DATA_W = 8,
  localparam int ADDR_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int FLAT_W = NUM_CH * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  lat_act_e          act,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] data,
  output logic [NUM_CH-1:0] sel,
  output logic [FLAT_W-1:0] in_next,
  output logic [FLAT_W-1:0] in_cur
);

  // One-hot channel decode; codes beyond NUM_CH select nothing.
  function automatic logic [NUM_CH-1:0] decode_addr(input logic [ADDR_W-1:0] a);
    logic [NUM_CH-1:0] oh;
    oh = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (a == ADDR_W'(i)) begin
        oh[i] = 1'b1;
      end
    end
    return oh;
  endfunction

  logic wr_active;

  assign wr_active = act_updates(act);
  assign sel       = wr_active ? decode_addr(addr) : '0;

  generate
    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      logic [DATA_W-1:0] stage_q;

      assign in_next[c*DATA_W +: DATA_W] = sel[c] ? data : stage_q;
      assign in_cur[c*DATA_W +: DATA_W]  = stage_q;

      always_ff @(posedge clk) begin
        if (!rst_n) begin
          stage_q <= '0;
        end else begin
          stage_q <= in_next[c*DATA_W +: DATA_W];
        end
      end
    end
  endgenerate

endmodule

// File: rtl/qdl_dac_bank.sv
module qdl_dac_bank
  import qdl_pkg::*;
#(
  parameter  int NUM_CH = 4,
  parameter  int DATA_W = 8,
  localparam int FLAT_W = NUM_CH * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  lat_act_e          act,
  input  logic [FLAT_W-1:0] src,
  output logic [FLAT_W-1:0] dac
);

  logic take;

  assign take = act_updates(act);

  generate
    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      logic [DATA_W-1:0] code_q;

      always_ff @(posedge clk) begin
        if (!rst_n) begin
          code_q <= '0;
        end else if (take) begin
          code_q <= src[c*DATA_W +: DATA_W];
        end
      end

      assign dac[c*DATA_W +: DATA_W] = code_q;
    end
  endgenerate

endmodule

// File: rtl/quad_dac_latch.sv
module quad_dac_latch
  import qdl_pkg::*;
#(
  parameter  int NUM_CH = 4,
  parameter  int DATA_W = 8,
  localparam int ADDR_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int FLAT_W = NUM_CH * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_n,
  input  logic              load_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] data,
  output logic [FLAT_W-1:0] dac_code
);

  // Named internal events, visible to the bound checker.
  lat_act_e          wr_act;
  lat_act_e          ld_act;
  logic              wr_rise;
  logic              ld_rise;
  logic [NUM_CH-1:0] sel;
  logic [FLAT_W-1:0] in_next;
  logic [FLAT_W-1:0] in_cur;

  qdl_strobe_track u_wr_track (
    .clk      (clk),
    .rst_n    (rst_n),
    .strobe_n (wr_n),
    .act      (wr_act),
    .rise     (wr_rise)
  );

  qdl_strobe_track u_ld_track (
    .clk      (clk),
    .rst_n    (rst_n),
    .strobe_n (load_n),
    .act      (ld_act),
    .rise     (ld_rise)
  );

  qdl_input_bank #(
    .NUM_CH (NUM_CH),
    .DATA_W (DATA_W)
  ) u_inputs (
    .clk     (clk),
    .rst_n   (rst_n),
    .act     (wr_act),
    .addr    (addr),
    .data    (data),
    .sel     (sel),
    .in_next (in_next),
    .in_cur  (in_cur)
  );

  // Output stage loads from the staging next-state so both low = flow-through.
  qdl_dac_bank #(
    .NUM_CH (NUM_CH),
    .DATA_W (DATA_W)
  ) u_outputs (
    .clk   (clk),
    .rst_n (rst_n),
    .act   (ld_act),
    .src   (in_next),
    .dac   (dac_code)
  );

endmodule

// File: rtl/quad_dac_latch_chk.sv
module quad_dac_latch_chk #(
  parameter  int NUM_CH = 4,
  parameter  int DATA_W = 8,
  localparam int ADDR_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int FLAT_W = NUM_CH * DATA_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_n,
  input logic              load_n,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] data,
  input logic [FLAT_W-1:0] dac_code,
  input logic [FLAT_W-1:0] in_cur,
  input logic              wr_rise,
  input logic              ld_rise,
  input logic [NUM_CH-1:0] sel
);

  function automatic logic [DATA_W-1:0] lane(input logic [FLAT_W-1:0] v, input int idx);
    return v[idx*DATA_W +: DATA_W];
  endfunction

  logic addr_ok;
  assign addr_ok = (int'(addr) < NUM_CH);

  logic past_rst_low = 1'b0;
  always_ff @(posedge clk) begin
    past_rst_low <= !rst_n;
  end

  // R1
  always @(posedge clk) begin
    if (past_rst_low) begin
      reset_zero_chk: assert (dac_code == '0 && in_cur == '0);
    end
  end

  // R2
  wr_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_n && addr_ok) |=> lane(in_cur, int'($past(addr))) == $past(data));

  // R2
  sel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sel));

  // R3
  wr_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_rise && addr_ok) |=> lane(in_cur, int'($past(addr))) == $past(data));

  // R4
  wr_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_n && !wr_rise) |=> $stable(in_cur));

  // R5
  ld_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load_n && !ld_rise) |=> $stable(dac_code));

  // R6
  ld_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load_n |=> dac_code == in_cur);

  // R7
  ld_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld_rise |=> dac_code == in_cur);

  // R8
  flow_through_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_n && !load_n && addr_ok) |=> lane(dac_code, int'($past(addr))) == $past(data));

  // R9
  quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_n && !wr_rise && load_n && !ld_rise) |=> ($stable(in_cur) && $stable(dac_code)));

endmodule

bind quad_dac_latch quad_dac_latch_chk #(
  .NUM_CH (NUM_CH),
  .DATA_W (DATA_W)
) chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .wr_n     (wr_n),
  .load_n   (load_n),
  .addr     (addr),
  .data     (data),
  .dac_code (dac_code),
  .in_cur   (in_cur),
  .wr_rise  (wr_rise),
  .ld_rise  (ld_rise),
  .sel      (sel)
);

// File: tb/quad_dac_latch_tb_top.sv
module quad_dac_latch_tb_top;

  localparam int NCH = 4;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_n;
  logic        load_n;
  logic [1:0]  addr;
  logic [7:0]  data;
  logic [31:0] dac_code;

  always #4 clk = ~clk;

  quad_dac_latch dut_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_n     (wr_n),
    .load_n   (load_n),
    .addr     (addr),
    .data     (data),
    .dac_code (dac_code)
  );

  int    checks = 0;
  int    fails  = 0;
  int    cyc    = 0;
  bit    cmp_on = 1'b0;
  bit    done   = 1'b0;
  string cur_req = "R1";

  // Behavioural reference: staging and output values as plain integers.
  int m_in [NCH];
  int m_out[NCH];
  bit m_wr_prev = 1'b1;
  bit m_ld_prev = 1'b1;

  always @(posedge clk) begin : ref_model
    int nxt[NCH];
    if (rst_n !== 1'b1) begin
      for (int c = 0; c < NCH; c++) begin
        m_in[c]  = 0;
        m_out[c] = 0;
      end
      m_wr_prev = 1'b1;
      m_ld_prev = 1'b1;
    end else begin
      nxt = m_in;
      if (!wr_n || !m_wr_prev) nxt[addr] = int'(data);
      if (!load_n || !m_ld_prev) m_out = nxt;
      m_in      = nxt;
      m_wr_prev = wr_n;
      m_ld_prev = load_n;
    end
  end

  task automatic check(input string req, input string what,
                       input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s got=%02h exp=%02h", req, what, got, exp);
    end
  endtask

  function automatic logic [7:0] lane_of(input int c);
    return dac_code[c*8 +: 8];
  endfunction

  // Every cycle: outputs against the model.
  always @(negedge clk) begin
    if (cmp_on && !done) begin
      for (int c = 0; c < NCH; c++) begin
        check(cur_req, $sformatf("model lane%0d", c), lane_of(c), 8'(m_out[c]));
      end
    end
  end

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      done = 1'b1;
      fails++;
      $display("FAIL watchdog got=%0d exp<=20000 cycles", cyc);
      summary();
      $finish;
    end
  end

  task automatic drive(input bit w, input bit l, input logic [1:0] a, input logic [7:0] d);
    wr_n   = w;
    load_n = l;
    addr   = a;
    data   = d;
    @(negedge clk);
  endtask

  logic [7:0] vals[NCH] = '{8'h5A, 8'hC3, 8'h81, 8'h7E};

  initial begin
    // R1: reset dominates active strobes.
    rst_n = 1'b0; wr_n = 1'b0; load_n = 1'b0; addr = 2'd1; data = 8'hFF;
    repeat (3) @(negedge clk);
    for (int c = 0; c < NCH; c++) check("R1", "reset out", lane_of(c), 8'h00);
    rst_n = 1'b1; wr_n = 1'b1; load_n = 1'b1;
    cmp_on = 1'b1;
    @(negedge clk);
    drive(1, 0, 2'd0, 8'h00);
    drive(1, 1, 2'd0, 8'h00);
    for (int c = 0; c < NCH; c++) check("R1", "staging zero", lane_of(c), 8'h00);

    // R3 / R4: write pulses, release edge carries the final byte.
    for (int k = 0; k < NCH; k++) begin
      cur_req = "R3";
      drive(0, 1, 2'(k), vals[k] ^ 8'h3C);
      drive(1, 1, 2'(k), vals[k]);
      cur_req = "R4";
      drive(1, 1, 2'(k + 1), ~vals[k]);
    end
    // R5: outputs untouched by writes while load idles.
    for (int c = 0; c < NCH; c++) check("R5", "held out", lane_of(c), 8'h00);

    // R9: both idle, bus toggling.
    cur_req = "R9";
    for (int i = 0; i < 4; i++) drive(1, 1, 2'(i), 8'(i * 37));
    for (int c = 0; c < NCH; c++) check("R9", "quiet out", lane_of(c), 8'h00);

    // R6: level load copies staging.
    cur_req = "R6";
    drive(1, 0, 2'd0, 8'h00);
    for (int c = 0; c < NCH; c++) check("R6", "load level", lane_of(c), vals[c]);

    // R7: load release in the same cycle as an active write to lane 3.
    cur_req = "R7";
    drive(0, 1, 2'd3, 8'h44);
    check("R7", "release lane3", lane_of(3), 8'h44);
    check("R7", "release lane0", lane_of(0), vals[0]);
    cur_req = "R5";
    drive(1, 1, 2'd3, 8'h00);
    check("R5", "hold lane3", lane_of(3), 8'h44);

    // R2: plain write to lane 2 then a load pulse.
    cur_req = "R2";
    drive(0, 1, 2'd2, 8'h21);
    drive(1, 1, 2'd2, 8'h21);
    drive(1, 0, 2'd1, 8'hEE);
    check("R2", "lane2 written", lane_of(2), 8'h21);
    check("R2", "lane1 untouched", lane_of(1), vals[1]);
    check("R2", "lane3 released", lane_of(3), 8'h00);
    drive(1, 1, 2'd1, 8'hEE);

    // R8: transparent sweep over every lane.
    cur_req = "R8";
    for (int i = 0; i < 16; i++) begin
      drive(0, 0, 2'(i), 8'(i * 17 + 3));
      check("R8", $sformatf("flow lane%0d", i % 4), lane_of(i % 4), 8'(i * 17 + 3));
    end
    drive(1, 1, 2'd0, 8'h00);

    // Random mix against the model.
    cur_req = "R2";
    for (int i = 0; i < 400; i++) begin
      drive(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
            2'($urandom_range(0, 3)), 8'($urandom));
    end

    // R1: reset in mid-run while both strobes are low.
    cur_req = "R1";
    rst_n = 1'b0;
    drive(0, 0, 2'd2, 8'hA5);
    rst_n = 1'b1;
    for (int c = 0; c < NCH; c++) check("R1", "mid reset", lane_of(c), 8'h00);
    drive(1, 1, 2'd0, 8'h00);
    drive(1, 1, 2'd0, 8'h00);

    done = 1'b1;
    summary();
    $finish;
  end

endmodule